// File: doc/BRIEF.md
# DMA Controller-Wide Command, Mask and Status Block

This block holds the registers that apply to a whole four-channel DMA controller rather than to one channel's address or count. A host bus writes and reads sixteen byte-wide ports. Only the upper eight (port index 8 to 15, selected by `port_i[3]`) belong to this block. Through them software loads the command byte, raises or drops software requests, masks channels one at a time or all at once, programs each channel's mode byte, clears the byte-pointer flip-flop, and issues a master clear. Reads return the status byte or the mask.

The per-channel register bank sits next to this block. It receives the mask bits, the request bits, the mode bytes and a one-cycle pulse that clears its byte-pointer flip-flop. It returns per-channel terminal-count pulses, which this block latches into the status byte. Peripheral models hold or release a channel's request through dedicated inputs.

Command values that ask for features this controller does not provide are refused, and the stored command is left as it was. Of the command bits, only the controller-disable bit (bit 2) can be set.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, `mask_o` is 4'hF, `req_o` and the terminal-count status bits are 0, `ctl_disable_o` is 0, every mode byte is 0, `ff_clr_o` is 0 and `rdata_o` is 0.
- R2: A write to port 8 is accepted only when its data is 8'h00 or 8'h04, and sets `ctl_disable_o` to data bit 2. Any other value leaves `ctl_disable_o` unchanged.
- R3: A write to port 9 selects channel data[1:0]. It sets `req_o[ch]` to data bit 2 and clears that channel's terminal-count status bit. For that channel it overrides `hold_i` and `release_i` in the same cycle.
- R4: A write to port 10 sets `mask_o[data[1:0]]` to data bit 2. The other mask bits are unchanged.
- R5: A write to port 11 stores the whole data byte as the mode of channel data[1:0]. Channel n's mode appears on `mode_o[8n+7:8n]`.
- R6: `ff_clr_o` is high for exactly the one cycle after a write to port 12 or port 13, and low otherwise.
- R7: A write to port 13 (master clear) sets `mask_o` to 4'hF and clears `req_o`, the terminal-count bits and `ctl_disable_o`. Any `tc_i`, `hold_i` or software request in that same cycle is overridden.
- R8: A write to port 14 clears every mask bit. A write to port 15 loads `mask_o` from data[3:0].
- R9: A read of port 8 returns the status byte {req[3:0], tc[3:0]} on `rdata_o` in the next cycle, then clears the terminal-count bits. A `tc_i` pulse in the read cycle is kept.
- R10: A read of port 15 returns {4'h0, mask} on `rdata_o` in the next cycle. A read of any other port, and a cycle without a read, gives `rdata_o` = 0.
- R11: Outside a software request to the same channel, `hold_i[n]` sets `req_o[n]` and `release_i[n]` clears it. When both are high, hold wins.
- R12: A `tc_i[n]` pulse sets terminal-count status bit n, which stays set until it is cleared by a status read, a software request to channel n or a master clear.
- R13: Writes with `port_i[3]` = 0 change no register of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| port_i | input | 4 | Port index; the block responds to 8 to 15 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read strobe |
| hold_i | input | 4 | Per-channel request hold |
| release_i | input | 4 | Per-channel request release |
| tc_i | input | 4 | Per-channel terminal-count pulse from the channel bank |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Channel request bits (status high nibble) |
| mode_o | output | 32 | Four mode bytes, channel n at [8n+7:8n] |
| ctl_disable_o | output | 1 | Controller disable from the command byte |
| ff_clr_o | output | 1 | Byte-pointer flip-flop clear pulse |

## Verification
Every result of this block is due on the first rising edge after its stimulus. This applies to register updates from writes, to read data, to the flip-flop clear pulse and to the effect of hold, release and terminal-count inputs. A read sees the register values from before that edge, even when a write or a terminal-count pulse lands in the same cycle. The bench drives each stimulus on the falling edge and advances a behavioural model on the rising edge. It compares all outputs on the following falling edge, so each comparison falls exactly one register stage after the stimulus.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  typedef enum logic [2:0] {
    IX_CMD        = 3'd0,
    IX_SWREQ      = 3'd1,
    IX_SMASK      = 3'd2,
    IX_MODE       = 3'd3,
    IX_FFCLR      = 3'd4,
    IX_MCLR       = 3'd5,
    IX_UNMASK_ALL = 3'd6,
    IX_LOAD_MASK  = 3'd7
  } ctl_idx_e;

  typedef struct packed {
    logic we_cmd;
    logic we_swreq;
    logic we_smask;
    logic we_mode;
    logic ff_clr;
    logic mclr;
    logic unmask_all;
    logic load_mask;
    logic rd_status;
    logic rd_mask;
  } ctl_strb_t;

  // only the controller-disable bit may be set in an accepted command
  localparam logic [7:0] CMD_ALLOWED = 8'h04;
  localparam int unsigned SET_BIT = 2;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [3:0] port_i,
  output ctl_strb_t  strb_o
);

  always_comb begin
    strb_o = '0;
    if (wr_en_i && port_i[3]) begin
      unique case (ctl_idx_e'(port_i[2:0]))
        IX_CMD:        strb_o.we_cmd     = 1'b1;
        IX_SWREQ:      strb_o.we_swreq   = 1'b1;
        IX_SMASK:      strb_o.we_smask   = 1'b1;
        IX_MODE:       strb_o.we_mode    = 1'b1;
        IX_FFCLR:      strb_o.ff_clr     = 1'b1;
        IX_MCLR:       strb_o.mclr       = 1'b1;
        IX_UNMASK_ALL: strb_o.unmask_all = 1'b1;
        IX_LOAD_MASK:  strb_o.load_mask  = 1'b1;
        default:       strb_o.we_cmd     = 1'b0;
      endcase
    end
    if (rd_en_i && port_i[3]) begin
      strb_o.rd_status = (port_i[2:0] == IX_CMD);
      strb_o.rd_mask   = (port_i[2:0] == IX_LOAD_MASK);
    end
  end

endmodule

// File: rtl/dma_ctl_mask.sv
module dma_ctl_mask #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CW    = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclr_i,
  input  logic              unmask_all_i,
  input  logic              load_i,
  input  logic              single_i,
  input  logic [CW-1:0]     ch_i,
  input  logic              set_i,
  input  logic [NUM_CH-1:0] load_val_i,
  output logic [NUM_CH-1:0] mask_o
);

  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mask_q <= '1;
    else if (mclr_i)        mask_q <= '1;
    else if (unmask_all_i)  mask_q <= '0;
    else if (load_i)        mask_q <= load_val_i;
    else if (single_i)      mask_q[ch_i] <= set_i;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CW    = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclr_i,
  input  logic              swreq_i,
  input  logic [CW-1:0]     ch_i,
  input  logic              set_i,
  input  logic              rd_clr_i,
  input  logic [NUM_CH-1:0] hold_i,
  input  logic [NUM_CH-1:0] release_i,
  input  logic [NUM_CH-1:0] tc_i,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] tc_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sw_hit;
    logic req_q, req_d;
    logic tc_q, tc_d;

    assign sw_hit = swreq_i && (ch_i == CW'(c));

    always_comb begin
      req_d = req_q;
      if (hold_i[c])         req_d = 1'b1;
      else if (release_i[c]) req_d = 1'b0;
      if (sw_hit)            req_d = set_i;
      if (mclr_i)            req_d = 1'b0;
    end

    // a new terminal count is never lost to a same-cycle clear, except master clear
    always_comb begin
      tc_d = tc_q;
      if (rd_clr_i || sw_hit) tc_d = 1'b0;
      if (tc_i[c])            tc_d = 1'b1;
      if (mclr_i)             tc_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q <= 1'b0;
        tc_q  <= 1'b0;
      end else begin
        req_q <= req_d;
        tc_q  <= tc_d;
      end
    end

    assign req_o[c] = req_q;
    assign tc_o[c]  = tc_q;
  end

endmodule

// File: rtl/dma_ctl_mode_bank.sv
module dma_ctl_mode_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 8,
  localparam int unsigned CW    = $clog2(NUM_CH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CW-1:0]        ch_i,
  input  logic [DW-1:0]        data_i,
  output logic [NUM_CH*DW-1:0] mode_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    logic [DW-1:0] mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mode_q <= '0;
      else if (we_i && ch_i == CW'(c))    mode_q <= data_i;
    end

    assign mode_o[c*DW +: DW] = mode_q;
  end

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [3:0]           port_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]    hold_i,
  input  logic [NUM_CH-1:0]    release_i,
  input  logic [NUM_CH-1:0]    tc_i,
  output logic [NUM_CH-1:0]    mask_o,
  output logic [NUM_CH-1:0]    req_o,
  output logic [NUM_CH*DW-1:0] mode_o,
  output logic                 ctl_disable_o,
  output logic                 ff_clr_o
);

  localparam int unsigned CW = $clog2(NUM_CH);
  localparam int unsigned SW = 2 * NUM_CH;

  ctl_strb_t         strb;
  logic [CW-1:0]     ch;
  logic              set_bit;
  logic [NUM_CH-1:0] tc_bits;
  logic              cmd_ok;
  logic              disable_q;
  logic              ff_clr_q;
  logic [DW-1:0]     rdata_q, rdata_d;

  assign ch      = wdata_i[CW-1:0];
  assign set_bit = wdata_i[SET_BIT];

  dma_ctl_decode i_decode (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .port_i  (port_i),
    .strb_o  (strb)
  );

  dma_ctl_mask #(.NUM_CH(NUM_CH)) i_mask (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mclr_i       (strb.mclr),
    .unmask_all_i (strb.unmask_all),
    .load_i       (strb.load_mask),
    .single_i     (strb.we_smask),
    .ch_i         (ch),
    .set_i        (set_bit),
    .load_val_i   (wdata_i[NUM_CH-1:0]),
    .mask_o       (mask_o)
  );

  dma_ctl_status #(.NUM_CH(NUM_CH)) i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mclr_i    (strb.mclr),
    .swreq_i   (strb.we_swreq),
    .ch_i      (ch),
    .set_i     (set_bit),
    .rd_clr_i  (strb.rd_status),
    .hold_i    (hold_i),
    .release_i (release_i),
    .tc_i      (tc_i),
    .req_o     (req_o),
    .tc_o      (tc_bits)
  );

  dma_ctl_mode_bank #(.NUM_CH(NUM_CH), .DW(DW)) i_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (strb.we_mode),
    .ch_i   (ch),
    .data_i (wdata_i),
    .mode_o (mode_o)
  );

  // refuse any command that requests an unsupported feature
  assign cmd_ok = (wdata_i & ~DW'(CMD_ALLOWED)) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     disable_q <= 1'b0;
    else if (strb.mclr)              disable_q <= 1'b0;
    else if (strb.we_cmd && cmd_ok)  disable_q <= wdata_i[SET_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_clr_q <= 1'b0;
    else         ff_clr_q <= strb.ff_clr | strb.mclr;
  end

  always_comb begin
    rdata_d = '0;
    if (strb.rd_status)    rdata_d = DW'({req_o, tc_bits});
    else if (strb.rd_mask) rdata_d = DW'(mask_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o       = rdata_q;
  assign ctl_disable_o = disable_q;
  assign ff_clr_o      = ff_clr_q;

  initial begin
    if (SW > DW) $error("status byte wider than data bus");
  end

endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic [3:0]           port_i,
  input logic [DW-1:0]        wdata_i,
  input logic [DW-1:0]        rdata_o,
  input logic [NUM_CH-1:0]    hold_i,
  input logic [NUM_CH-1:0]    release_i,
  input logic [NUM_CH-1:0]    tc_i,
  input logic [NUM_CH-1:0]    mask_o,
  input logic [NUM_CH-1:0]    req_o,
  input logic [NUM_CH*DW-1:0] mode_o,
  input logic                 ctl_disable_o,
  input logic                 ff_clr_o
);

  localparam int unsigned CW = $clog2(NUM_CH);

  p_cmd_reject_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && port_i == 4'd8 && (wdata_i & ~DW'(8'h04)) != '0) |=> $stable(ctl_disable_o));

  p_swreq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && port_i == 4'd9) |=> req_o[$past(wdata_i[CW-1:0])] == $past(wdata_i[2]));

  p_smask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && port_i == 4'd10) |=> mask_o[$past(wdata_i[CW-1:0])] == $past(wdata_i[2]));

  p_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && port_i == 4'd11) |=> mode_o[DW*$past(wdata_i[CW-1:0]) +: DW] == $past(wdata_i));

  p_ffclr_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (port_i == 4'd12 || port_i == 4'd13)) |=> ff_clr_o);

  p_ffclr_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (port_i == 4'd12 || port_i == 4'd13)) |=> !ff_clr_o);

  p_mclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && port_i == 4'd13) |=> (mask_o == '1 && req_o == '0 && !ctl_disable_o));

  p_unmask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && port_i == 4'd14) |=> mask_o == '0);

  p_rd_other_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && (port_i == 4'd8 || port_i == 4'd15)) |=> rdata_o == '0);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i != '0 && !(wr_en_i && port_i[3])) |=> ((req_o & $past(hold_i)) == $past(hold_i)));

  p_low_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !port_i[3] && !rd_en_i && hold_i == '0 && release_i == '0 && tc_i == '0)
    |=> ($stable(mask_o) && $stable(req_o) && $stable(mode_o) && $stable(ctl_disable_o)));

endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NUM_CH(NUM_CH), .DW(DW)) i_chk (.*);

// File: tb/test_dma_ctl_regs.sv
`timescale 1ns/1ps
module test_dma_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  port = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  hold = '0, rel = '0, tc = '0;
  logic [7:0]  rdata;
  logic [3:0]  mask, req;
  logic [31:0] mode;
  logic        dis, ffc;

  always #4 clk = ~clk;

  dma_ctl_regs i_dma_ctl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en), .port_i(port),
    .wdata_i(wdata), .rdata_o(rdata), .hold_i(hold), .release_i(rel), .tc_i(tc),
    .mask_o(mask), .req_o(req), .mode_o(mode), .ctl_disable_o(dis), .ff_clr_o(ffc)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  bit [3:0] m_mask = 4'hF, m_req = '0, m_tc = '0;
  bit       m_dis = 0, m_ff = 0;
  bit [7:0] m_rd = '0;
  bit [7:0] m_mode [4] = '{default: 8'h00};

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", cur_req, what, got, exp);
    end
  endtask

  task automatic model_step();
    bit [3:0] nmask = m_mask, nreq = m_req, ntc = m_tc;
    bit nd = m_dis, nff = 0;
    bit [7:0] nrd = 8'h00;
    int ch = int'(wdata[1:0]);
    if (rd_en && port == 4'd8) begin nrd = {m_req, m_tc}; ntc = '0; end
    else if (rd_en && port == 4'd15) nrd = {4'h0, m_mask};
    for (int c = 0; c < 4; c++) begin
      if (hold[c]) nreq[c] = 1'b1;
      else if (rel[c]) nreq[c] = 1'b0;
    end
    if (wr_en && port >= 4'd8) begin
      case (port)
        4'd8:  if (wdata == 8'h00 || wdata == 8'h04) nd = wdata[2];
        4'd9:  begin nreq[ch] = wdata[2]; ntc[ch] = 1'b0; end
        4'd10: nmask[ch] = wdata[2];
        4'd11: m_mode[ch] = wdata;
        4'd12: nff = 1'b1;
        4'd14: nmask = 4'h0;
        4'd15: nmask = wdata[3:0];
        default: ;
      endcase
    end
    ntc |= tc;
    if (wr_en && port == 4'd13) begin
      nmask = 4'hF; nreq = '0; ntc = '0; nd = 1'b0; nff = 1'b1;
    end
    m_mask = nmask; m_req = nreq; m_tc = ntc; m_dis = nd; m_ff = nff; m_rd = nrd;
  endtask

  task automatic compare();
    chk("mask_o", 32'(mask), 32'(m_mask));
    chk("req_o", 32'(req), 32'(m_req));
    chk("ctl_disable_o", 32'(dis), 32'(m_dis));
    chk("ff_clr_o", 32'(ffc), 32'(m_ff));
    chk("rdata_o", 32'(rdata), 32'(m_rd));
    chk("mode_o", mode, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic drv(bit we, bit re, bit [3:0] p, bit [7:0] d,
                     bit [3:0] h = 0, bit [3:0] r = 0, bit [3:0] t = 0);
    wr_en = we; rd_en = re; port = p; wdata = d; hold = h; rel = r; tc = t;
    cyc();
    wr_en = 0; rd_en = 0; hold = 0; rel = 0; tc = 0;
  endtask

  task automatic wr(bit [3:0] p, bit [7:0] d); drv(1, 0, p, d); endtask
  task automatic rd(bit [3:0] p); drv(0, 1, p, 8'h00); endtask
  task automatic idle(); drv(0, 0, 4'd0, 8'h00); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset values
    cur_req = "R1"; idle(); idle();

    cur_req = "R2";
    wr(4'd8, 8'h04); wr(4'd8, 8'h10); wr(4'd8, 8'h05);
    wr(4'd8, 8'h00); wr(4'd8, 8'hFB); wr(4'd8, 8'h04);

    cur_req = "R4";
    wr(4'd10, 8'h02); wr(4'd10, 8'h00); wr(4'd10, 8'h06); wr(4'd10, 8'hF9);

    cur_req = "R8";
    wr(4'd14, 8'hFF); wr(4'd15, 8'hA5); wr(4'd15, 8'h0A);

    cur_req = "R5";
    wr(4'd11, 8'h58); wr(4'd11, 8'h95); wr(4'd11, 8'hE6); wr(4'd11, 8'h2B); wr(4'd11, 8'h44);

    cur_req = "R12";
    drv(0, 0, 4'd0, 8'h00, 0, 0, 4'b0101); idle();
    drv(0, 0, 4'd0, 8'h00, 0, 0, 4'b0010);

    cur_req = "R9";
    rd(4'd8); idle();
    drv(0, 0, 4'd0, 8'h00, 0, 0, 4'b1001);
    drv(0, 1, 4'd8, 8'h00, 0, 0, 4'b0100);
    rd(4'd8); rd(4'd8);

    cur_req = "R3";
    drv(0, 0, 4'd0, 8'h00, 0, 0, 4'b1111);
    wr(4'd9, 8'h05); wr(4'd9, 8'h07); wr(4'd9, 8'h01); rd(4'd8);
    drv(1, 0, 4'd9, 8'h02, 4'b0100, 0, 0);
    drv(1, 0, 4'd9, 8'h04, 0, 4'b0001, 0);

    cur_req = "R11";
    drv(0, 0, 4'd0, 8'h00, 4'b1010, 0, 0);
    drv(0, 0, 4'd0, 8'h00, 4'b0011, 4'b0011, 0);
    drv(0, 0, 4'd0, 8'h00, 0, 4'b1111, 0);

    cur_req = "R10";
    wr(4'd15, 8'h06); rd(4'd15); rd(4'd9); rd(4'd12); rd(4'd3); idle();

    cur_req = "R6";
    wr(4'd12, 8'h00); idle(); wr(4'd12, 8'hFF); wr(4'd12, 8'h00); idle();

    cur_req = "R7";
    wr(4'd8, 8'h04); wr(4'd14, 8'h00);
    drv(0, 0, 4'd0, 8'h00, 4'b1111, 0, 4'b1111);
    drv(1, 0, 4'd13, 8'h00, 4'b0001, 0, 4'b0010);
    rd(4'd8); idle();

    cur_req = "R13";
    wr(4'd14, 8'h00); wr(4'd11, 8'h91);
    for (int p = 0; p < 8; p++) wr(4'(p), 8'hFF);
    idle();

    cur_req = "R11";
    for (int i = 0; i < 400; i++) begin
      bit [3:0] p;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = {1'b1, lfsr[2:0]};
      if (p == 4'd13 && lfsr[9:8] != 2'b00) p = 4'd9;
      drv(lfsr[3], lfsr[4], lfsr[5] ? p : {lfsr[6], lfsr[2:0]}, lfsr[15:8],
          lfsr[11:8] & {4{lfsr[7]}}, lfsr[15:12] & {4{lfsr[6]}}, lfsr[12:9] & {4{lfsr[1]}});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule